// File: doc/BRIEF.md
# Framed Sample Burst Generator

This block produces a burst of framed sample packets on a 64-bit stream that uses valid, ready and last. One start pulse captures the burst settings: how many packets to send, how many 32-bit samples each packet holds, a 32-bit stream identifier, a sample pattern, an optional 64-bit timestamp and the first sequence number. Each packet is sent as a header word, then a timestamp word if one applies, then sample words. Each sample word carries two samples.

The header word carries these fields: a has-time flag, an end-of-burst marker, a 12-bit packet counter, a length field that also counts the header and timestamp words, and the stream identifier. The sample pattern can be a running ramp, a fixed level, or a value tagged with the sequence number. When the final word of the burst is accepted, a one-cycle done pulse follows. The consumer controls the pace through ready. No word is lost or sent twice while ready is low.

Top module: `pkt_burst_gen`

## Requirements
- R1: Header word bits, MSB first: bit 63 = 0, bit 62 = 0, bit 61 = has-time flag, bit 60 = end-of-burst flag, bits 59:48 = sequence number, bits 47:32 = length, bits 31:0 = stream ID captured at start.
- R2: The length field equals the sample count plus 2, plus a further 2 when the packet carries a timestamp word.
- R3: When `cfg_time_en` is 1, only the first packet sets the has-time flag and sends `cfg_time` as the word directly after its header. Every later packet clears the flag and has no timestamp word.
- R4: The end-of-burst flag is 1 on the last packet of the burst only. In a one-packet burst it is 1 on that packet.
- R5: The first packet uses `cfg_seq_start` as its sequence number. Each later packet adds one, and the value wraps modulo 4096.
- R6: A packet of N samples has ceil(N/2) sample words. Each word is {s, s+1}, with s in bits 63:32, and the next word starts at s+2. `out_last` is 1 on the final word of the packet only. With N = 0, the header word (or the timestamp word, if present) carries last.
- R7: Pattern 2'd0 (ramp, and 2'd3 acts the same way): the first packet starts at `cfg_start_value`. Each later packet starts at the previous packet's start plus its sample count, modulo 2^32.
- R8: Pattern 2'd1 (constant): every packet starts at 16384 (1<<14).
- R9: Pattern 2'd2 (tagged): each packet starts at {4'b0, sequence number, `cfg_start_value`[15:0]}.
- R10: `out_valid` is 0 for at least one cycle after the last word of each packet.
- R11: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and leaves `out_data` and `out_last` unchanged.
- R12: A start pulse is ignored while a burst is running. A start pulse with `cfg_pkt_count` = 0 is ignored. Settings that change after start have no effect on the burst.
- R13: `done` is 1 for exactly one cycle: the cycle after the final word of the burst is accepted. It is 0 at all other times.
- R14: A synchronous active-high `rst` returns the block to idle, with `out_valid` and `done` at 0, even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a burst when idle |
| cfg_pkt_count | input | CNT_W | Packets in the burst |
| cfg_samples | input | NSAMP_W | Samples per packet |
| cfg_stream_id | input | 32 | Stream identifier placed in every header |
| cfg_pattern | input | 2 | Sample pattern: 0 ramp, 1 constant, 2 tagged, 3 ramp |
| cfg_time_en | input | 1 | First packet carries a timestamp |
| cfg_time | input | 64 | Timestamp value |
| cfg_seq_start | input | 12 | First sequence number |
| cfg_start_value | input | 32 | Ramp start value; low half used as the tag |
| out_data | output | 64 | Stream data |
| out_valid | output | 1 | Stream data valid |
| out_last | output | 1 | Final word of a packet |
| out_ready | input | 1 | Consumer ready |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The assertions check four timing rules on every cycle: a stalled word holds steady, a packet's final word is followed by an idle cycle, done appears only directly after an accepted final word and never together with valid, and reset leaves the outputs idle. The other rules can only be shown by the bench's scenarios. These cover the contents of each header field, the length arithmetic, the timestamp on the first packet only, the sequence wrap, the start value of each pattern and whether it carries over between packets, and start pulses that must be ignored. For these, the bench builds the expected word stream arithmetically and checks it under steady, periodic and pseudo-random ready patterns.

// File: rtl/pkt_burst_pkg.sv
package pkt_burst_pkg;

   localparam int SEQ_W     = 12;
   localparam int LEN_W     = 16;
   localparam int SID_W     = 32;
   localparam int WORD_W    = 64;
   localparam int SAMPLE_W  = 32;
   localparam int TAG_LOW_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_TIME,
      ST_SAMP,
      ST_GAP
   } gen_state_e;

   typedef enum logic [1:0] {
      PAT_RAMP     = 2'd0,
      PAT_CONST    = 2'd1,
      PAT_TAGGED   = 2'd2,
      PAT_RAMP_ALT = 2'd3
   } pattern_e;

   typedef struct packed {
      logic             pkt_type;
      logic             trailer;
      logic             has_time;
      logic             eob;
      logic [SEQ_W-1:0] seq;
      logic [LEN_W-1:0] len;
      logic [SID_W-1:0] sid;
   } hdr_word_t;

endpackage

// File: rtl/pkt_hdr_fmt.sv
module pkt_hdr_fmt
   import pkt_burst_pkg::*;
#(
   parameter int NSAMP_W = 16
) (
   input  logic               has_time,
   input  logic               eob,
   input  logic [SEQ_W-1:0]   seq,
   input  logic [NSAMP_W-1:0] nsamp,
   input  logic [SID_W-1:0]   sid,
   output logic [WORD_W-1:0]  word
);

   localparam logic [LEN_W-1:0] BASE_WORDS = LEN_W'(2);
   localparam logic [LEN_W-1:0] TIME_WORDS = LEN_W'(2);

   hdr_word_t        hdr;
   logic [LEN_W-1:0] len_val;

   always_comb begin
      len_val = LEN_W'(nsamp) + BASE_WORDS;
      if (has_time) len_val = len_val + TIME_WORDS;
   end

   always_comb begin
      hdr.pkt_type = 1'b0;
      hdr.trailer  = 1'b0;
      hdr.has_time = has_time;
      hdr.eob      = eob;
      hdr.seq      = seq;
      hdr.len      = len_val;
      hdr.sid      = sid;
   end

   assign word = hdr;

endmodule

// File: rtl/pkt_sample_src.sv
module pkt_sample_src
   import pkt_burst_pkg::*;
#(
   parameter int                   NSAMP_W     = 16,
   parameter int                   LANES       = 2,
   parameter logic [SAMPLE_W-1:0]  CONST_LEVEL = 32'h0000_4000
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      burst_begin,
   input  logic [SAMPLE_W-1:0]       in_start,
   input  gen_state_e                state,
   input  logic                      fire,
   input  logic                      pkt_end,
   input  pattern_e                  mode,
   input  logic [SEQ_W-1:0]          seq,
   input  logic [NSAMP_W-1:0]        nsamp,
   output logic [LANES*SAMPLE_W-1:0] word
);

   localparam logic [SAMPLE_W-1:0] STEP = SAMPLE_W'(LANES);

   logic [SAMPLE_W-1:0]  base_q;
   logic [SAMPLE_W-1:0]  cur_q;
   logic [TAG_LOW_W-1:0] tag_low_q;
   logic [SAMPLE_W-1:0]  pkt_start;

   always_comb begin
      case (mode)
         PAT_CONST:  pkt_start = CONST_LEVEL;
         PAT_TAGGED: pkt_start = SAMPLE_W'({seq, tag_low_q});
         default:    pkt_start = base_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q    <= '0;
         tag_low_q <= '0;
      end else if (burst_begin) begin
         base_q    <= in_start;
         tag_low_q <= in_start[TAG_LOW_W-1:0];
      end else if (pkt_end) begin
         base_q    <= base_q + SAMPLE_W'(nsamp);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                  cur_q <= '0;
      else if (state != ST_SAMP) cur_q <= pkt_start;
      else if (fire)            cur_q <= cur_q + STEP;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign word[(LANES-1-l)*SAMPLE_W +: SAMPLE_W] = cur_q + SAMPLE_W'(l);
   end

endmodule

// File: rtl/pkt_burst_ctrl.sv
module pkt_burst_ctrl
   import pkt_burst_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NSAMP_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [CNT_W-1:0]   in_count,
   input  logic [NSAMP_W-1:0] in_nsamp,
   input  logic [SID_W-1:0]   in_sid,
   input  logic [1:0]         in_mode,
   input  logic               in_time_en,
   input  logic [WORD_W-1:0]  in_time,
   input  logic [SEQ_W-1:0]   in_seq0,
   input  logic               out_ready,
   output gen_state_e         state,
   output logic               word_valid,
   output logic               fire,
   output logic               word_last,
   output logic               pkt_end,
   output logic               burst_begin,
   output logic               time_now,
   output logic               eob,
   output logic               done,
   output logic [SEQ_W-1:0]   seq,
   output logic [NSAMP_W-1:0] nsamp,
   output logic [SID_W-1:0]   sid,
   output pattern_e           mode,
   output logic [WORD_W-1:0]  time_word
);

   gen_state_e         state_q;
   logic [CNT_W-1:0]   pkts_left_q;
   logic [NSAMP_W-1:0] beats_left_q;
   logic [SEQ_W-1:0]   seq_q;
   logic               first_q;
   logic [NSAMP_W-1:0] nsamp_q;
   logic [SID_W-1:0]   sid_q;
   pattern_e           mode_q;
   logic               time_en_q;
   logic [WORD_W-1:0]  time_q;
   logic               done_q;

   logic [NSAMP_W:0]   nsamp_rounded;
   logic [NSAMP_W-1:0] beats_total;
   logic               no_beats;

   assign nsamp_rounded = {1'b0, nsamp_q} + {{NSAMP_W{1'b0}}, 1'b1};
   assign beats_total   = nsamp_rounded[NSAMP_W:1];
   assign no_beats      = (beats_total == '0);

   assign time_now    = first_q & time_en_q;
   assign eob         = (pkts_left_q == CNT_W'(1));
   assign word_valid  = (state_q == ST_HDR) || (state_q == ST_TIME) || (state_q == ST_SAMP);
   assign fire        = word_valid & out_ready;
   assign burst_begin = (state_q == ST_IDLE) & start & (in_count != '0);

   always_comb begin
      case (state_q)
         ST_HDR:  word_last = !time_now && no_beats;
         ST_TIME: word_last = no_beats;
         ST_SAMP: word_last = (beats_left_q == NSAMP_W'(1));
         default: word_last = 1'b0;
      endcase
   end

   assign pkt_end = fire & word_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q      <= ST_IDLE;
         pkts_left_q  <= '0;
         beats_left_q <= '0;
         seq_q        <= '0;
         first_q      <= 1'b0;
         nsamp_q      <= '0;
         sid_q        <= '0;
         mode_q       <= PAT_RAMP;
         time_en_q    <= 1'b0;
         time_q       <= '0;
         done_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (burst_begin) begin
                  pkts_left_q <= in_count;
                  nsamp_q     <= in_nsamp;
                  sid_q       <= in_sid;
                  mode_q      <= pattern_e'(in_mode);
                  time_en_q   <= in_time_en;
                  time_q      <= in_time;
                  seq_q       <= in_seq0;
                  first_q     <= 1'b1;
                  state_q     <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (fire && !word_last) begin
                  if (time_now) begin
                     state_q <= ST_TIME;
                  end else begin
                     state_q      <= ST_SAMP;
                     beats_left_q <= beats_total;
                  end
               end
            end
            ST_TIME: begin
               if (fire && !word_last) begin
                  state_q      <= ST_SAMP;
                  beats_left_q <= beats_total;
               end
            end
            ST_SAMP: begin
               if (fire) beats_left_q <= beats_left_q - NSAMP_W'(1);
            end
            ST_GAP:  state_q <= ST_HDR;
            default: state_q <= ST_IDLE;
         endcase
         if (pkt_end) begin
            if (eob) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else begin
               state_q     <= ST_GAP;
               pkts_left_q <= pkts_left_q - CNT_W'(1);
               seq_q       <= seq_q + SEQ_W'(1);
               first_q     <= 1'b0;
            end
         end
      end
   end

   assign state     = state_q;
   assign done      = done_q;
   assign seq       = seq_q;
   assign nsamp     = nsamp_q;
   assign sid       = sid_q;
   assign mode      = mode_q;
   assign time_word = time_q;

endmodule

// File: rtl/pkt_burst_gen.sv
module pkt_burst_gen
   import pkt_burst_pkg::*;
#(
   parameter int                  CNT_W       = 16,
   parameter int                  NSAMP_W     = 16,
   parameter logic [SAMPLE_W-1:0] CONST_LEVEL = 32'h0000_4000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [CNT_W-1:0]   cfg_pkt_count,
   input  logic [NSAMP_W-1:0] cfg_samples,
   input  logic [31:0]        cfg_stream_id,
   input  logic [1:0]         cfg_pattern,
   input  logic               cfg_time_en,
   input  logic [63:0]        cfg_time,
   input  logic [11:0]        cfg_seq_start,
   input  logic [31:0]        cfg_start_value,
   output logic [63:0]        out_data,
   output logic               out_valid,
   output logic               out_last,
   input  logic               out_ready,
   output logic               done
);

   localparam int LANES = WORD_W / SAMPLE_W;

   if (NSAMP_W < 1 || NSAMP_W > LEN_W) begin : g_bad_nsamp
      $error("NSAMP_W must lie between 1 and the length field width");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (LANES * SAMPLE_W != WORD_W) begin : g_bad_lanes
      $error("samples must tile the stream word exactly");
   end
   if (SAMPLE_W < SEQ_W + TAG_LOW_W) begin : g_bad_tag
      $error("sample width too narrow for the tagged pattern");
   end

   gen_state_e         state;
   logic               word_valid;
   logic               fire;
   logic               word_last;
   logic               pkt_end;
   logic               burst_begin;
   logic               time_now;
   logic               eob;
   logic [SEQ_W-1:0]   seq;
   logic [NSAMP_W-1:0] nsamp;
   logic [SID_W-1:0]   sid;
   pattern_e           mode;
   logic [WORD_W-1:0]  time_word;
   logic [WORD_W-1:0]  hdr_word;
   logic [WORD_W-1:0]  samp_word;

   pkt_burst_ctrl #(
      .CNT_W   (CNT_W),
      .NSAMP_W (NSAMP_W)
   ) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .in_count    (cfg_pkt_count),
      .in_nsamp    (cfg_samples),
      .in_sid      (cfg_stream_id),
      .in_mode     (cfg_pattern),
      .in_time_en  (cfg_time_en),
      .in_time     (cfg_time),
      .in_seq0     (cfg_seq_start),
      .out_ready   (out_ready),
      .state       (state),
      .word_valid  (word_valid),
      .fire        (fire),
      .word_last   (word_last),
      .pkt_end     (pkt_end),
      .burst_begin (burst_begin),
      .time_now    (time_now),
      .eob         (eob),
      .done        (done),
      .seq         (seq),
      .nsamp       (nsamp),
      .sid         (sid),
      .mode        (mode),
      .time_word   (time_word)
   );

   pkt_hdr_fmt #(
      .NSAMP_W (NSAMP_W)
   ) u_hdr (
      .has_time (time_now),
      .eob      (eob),
      .seq      (seq),
      .nsamp    (nsamp),
      .sid      (sid),
      .word     (hdr_word)
   );

   pkt_sample_src #(
      .NSAMP_W     (NSAMP_W),
      .LANES       (LANES),
      .CONST_LEVEL (CONST_LEVEL)
   ) u_samp (
      .clk         (clk),
      .rst         (rst),
      .burst_begin (burst_begin),
      .in_start    (cfg_start_value),
      .state       (state),
      .fire        (fire),
      .pkt_end     (pkt_end),
      .mode        (mode),
      .seq         (seq),
      .nsamp       (nsamp),
      .word        (samp_word)
   );

   always_comb begin
      case (state)
         ST_HDR:  out_data = hdr_word;
         ST_TIME: out_data = time_word;
         ST_SAMP: out_data = samp_word;
         default: out_data = '0;
      endcase
   end

   assign out_valid = word_valid;
   assign out_last  = word_last;

endmodule

// File: rtl/pkt_burst_gen_chk.sv
module pkt_burst_gen_chk (
   input logic        clk,
   input logic        rst,
   input logic [63:0] out_data,
   input logic        out_valid,
   input logic        out_last,
   input logic        out_ready,
   input logic        done
);

   assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   assert_gap_after_last_R10: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_last) |=> !out_valid);

   assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
      out_last |-> out_valid);

   assert_done_after_final_R13: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(out_valid && out_ready && out_last));

   assert_done_when_idle_R13: assert property (@(posedge clk) disable iff (rst)
      done |-> !out_valid);

   assert_reset_idle_R14: assert property (@(posedge clk)
      rst |=> (!out_valid && !done));

endmodule

bind pkt_burst_gen pkt_burst_gen_chk u_chk (.*);

// File: tb/pkt_burst_gen_tb.sv
`timescale 1ns/1ps
module pkt_burst_gen_tb;

   localparam int CNT_W   = 16;
   localparam int NSAMP_W = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst;
   logic               start;
   logic [CNT_W-1:0]   cfg_pkt_count;
   logic [NSAMP_W-1:0] cfg_samples;
   logic [31:0]        cfg_stream_id;
   logic [1:0]         cfg_pattern;
   logic               cfg_time_en;
   logic [63:0]        cfg_time;
   logic [11:0]        cfg_seq_start;
   logic [31:0]        cfg_start_value;
   logic [63:0]        out_data;
   logic               out_valid;
   logic               out_last;
   logic               out_ready;
   logic               done;

   pkt_burst_gen #(.CNT_W(CNT_W), .NSAMP_W(NSAMP_W)) u_dut (
      .clk(clk), .rst(rst), .start(start),
      .cfg_pkt_count(cfg_pkt_count), .cfg_samples(cfg_samples),
      .cfg_stream_id(cfg_stream_id), .cfg_pattern(cfg_pattern),
      .cfg_time_en(cfg_time_en), .cfg_time(cfg_time),
      .cfg_seq_start(cfg_seq_start), .cfg_start_value(cfg_start_value),
      .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
      .out_ready(out_ready), .done(done)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic        last;
      logic [63:0] data;
   } exp_t;

   exp_t        exp_q[$];
   int          checks = 0;
   int          errors = 0;
   bit          summary_done = 0;
   logic [15:0] lfsr = 16'hACE1;
   int          cyc = 0;

   task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic build_expected(input int cnt, input int n, input logic [31:0] sid, input int mode,
                                 input bit ht, input logic [63:0] tm, input int seq0, input logic [31:0] sv);
      logic [31:0] base;
      base = sv;
      exp_q.delete();
      for (int p = 0; p < cnt; p++) begin
         logic [11:0] sq;
         bit          t;
         logic [15:0] len;
         int          beats;
         logic [31:0] s0;
         sq    = 12'((seq0 + p) % 4096);
         t     = ht && (p == 0);
         len   = 16'(n + 2 + (t ? 2 : 0));
         beats = (n + 1) / 2;
         exp_q.push_back('{2'd0, (beats == 0 && !t), {1'b0, 1'b0, t, (p == cnt - 1), sq, len, sid}});
         if (t) exp_q.push_back('{2'd1, (beats == 0), tm});
         case (mode)
            1:       s0 = 32'd16384;
            2:       s0 = {4'b0, sq, sv[15:0]};
            default: s0 = base;
         endcase
         for (int b = 0; b < beats; b++) begin
            logic [31:0] s;
            s = s0 + 32'(2 * b);
            exp_q.push_back('{2'd2, (b == beats - 1), {s, s + 32'd1}});
         end
         base = base + 32'(n);
      end
   endtask

   function automatic string kind_tag(input logic [1:0] k, input int mode);
      if (k == 2'd0) return "R1 R2 R3 R4 R5 header";
      if (k == 2'd1) return "R3 timestamp";
      case (mode)
         1:       return "R6 R8 constant sample";
         2:       return "R6 R9 tagged sample";
         default: return "R6 R7 ramp sample";
      endcase
   endfunction

   task automatic run_burst(input int cnt, input int n, input logic [31:0] sid, input int mode,
                            input bit ht, input logic [63:0] tm, input int seq0, input logic [31:0] sv,
                            input int rmode, input bit poke);
      bit          prev_last_hs = 0;
      bit          prev_stall   = 0;
      logic [64:0] stall_word   = '0;
      bit          finished     = 0;
      int          guard        = 0;
      build_expected(cnt, n, sid, mode, ht, tm, seq0, sv);
      cfg_pkt_count   = CNT_W'(cnt);
      cfg_samples     = NSAMP_W'(n);
      cfg_stream_id   = sid;
      cfg_pattern     = 2'(mode);
      cfg_time_en     = ht;
      cfg_time        = tm;
      cfg_seq_start   = 12'(seq0);
      cfg_start_value = sv;
      start           = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!finished && guard < 4000) begin
         bit r;
         cyc++;
         case (rmode)
            0:       r = 1'b1;
            1: begin
               r    = lfsr[0];
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            end
            default: r = (cyc % 3) != 2;
         endcase
         out_ready = r;
         if (prev_last_hs) begin
            check(!out_valid, "R10 idle cycle after packet", {64'd0, out_valid}, 65'd0);
            if (exp_q.size() == 0) begin
               check(done, "R13 done after final word", {64'd0, done}, 65'd1);
               finished = 1;
            end
         end
         if (done && !finished) check(1'b0, "R13 early done", {64'd0, done}, 65'd0);
         if (prev_stall)
            check(out_valid && ({out_last, out_data} == stall_word), "R11 stalled word held",
                  {out_last, out_data}, stall_word);
         prev_last_hs = 0;
         prev_stall   = 0;
         if (!finished && out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 extra word", {out_last, out_data}, 65'd0);
            end else if (r) begin
               exp_t e;
               e = exp_q.pop_front();
               check({out_last, out_data} == {e.last, e.data}, kind_tag(e.kind, mode),
                     {out_last, out_data}, {e.last, e.data});
               prev_last_hs = out_last;
            end else begin
               prev_stall = 1;
               stall_word = {out_last, out_data};
            end
         end
         if (!finished && poke && guard == 3) begin
            start           = 1'b1;
            cfg_pkt_count   = CNT_W'(5);
            cfg_samples     = NSAMP_W'(9);
            cfg_stream_id   = ~sid;
            cfg_pattern     = 2'(mode + 1);
            cfg_time_en     = !ht;
            cfg_time        = ~tm;
            cfg_seq_start   = 12'(seq0 + 100);
            cfg_start_value = ~sv;
         end else begin
            start = 1'b0;
         end
         guard++;
         @(negedge clk);
      end
      start = 1'b0;
      if (!finished) check(1'b0, "R6 burst incomplete", 65'(exp_q.size()), 65'd0);
      check(!done, "R13 done lasts one cycle", {64'd0, done}, 65'd0);
      if (poke) check(!out_valid, "R12 start ignored while busy", {64'd0, out_valid}, 65'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!summary_done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary_done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int idx;
      int nlist[6];
      nlist = '{0, 1, 2, 3, 4, 7};
      rst = 1'b1; start = 1'b0; out_ready = 1'b0;
      cfg_pkt_count = '0; cfg_samples = '0; cfg_stream_id = '0; cfg_pattern = '0;
      cfg_time_en = 1'b0; cfg_time = '0; cfg_seq_start = '0; cfg_start_value = '0;
      repeat (3) @(negedge clk);
      check(!out_valid && !done, "R14 reset state", {63'd0, out_valid, done}, 65'd0);
      rst = 1'b0;
      @(negedge clk);

      cfg_pkt_count = '0; cfg_samples = NSAMP_W'(4); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
         check(!out_valid && !done, "R12 zero-count start ignored", {63'd0, out_valid, done}, 65'd0);
         @(negedge clk);
      end

      idx = 0;
      for (int cnt = 1; cnt <= 3; cnt++)
         for (int ni = 0; ni < 6; ni++)
            for (int mode = 0; mode < 4; mode++)
               for (int ht = 0; ht < 2; ht++) begin
                  run_burst(cnt, nlist[ni], 32'hA500_0000 + 32'(idx), mode, ht[0],
                            {32'hC0DE_0000 + 32'(idx), 32'(idx * 7)},
                            (cnt == 3) ? 4094 : (idx * 37) % 4096,
                            32'h0001_0000 * 32'(idx) + 32'h0000_BEE5,
                            idx % 3, (idx % 5) == 0);
                  idx++;
               end

      run_burst(2, 40, 32'h1234_5678, 0, 1'b1, 64'hFEED_F00D_0BAD_CAFE, 4095, 32'hFFFF_FFF0, 1, 1'b1);
      run_burst(4, 5, 32'h0000_0001, 2, 1'b0, 64'd0, 4093, 32'hDEAD_1234, 2, 1'b0);

      cfg_pkt_count = CNT_W'(3); cfg_samples = NSAMP_W'(6); cfg_pattern = 2'd0;
      cfg_time_en = 1'b1; out_ready = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(!out_valid && !done, "R14 reset mid-burst", {63'd0, out_valid, done}, 65'd0);
      rst = 1'b0;
      @(negedge clk);
      check(!out_valid && !done, "R14 idle after reset", {63'd0, out_valid, done}, 65'd0);
      run_burst(1, 3, 32'h0BAD_BEEF, 1, 1'b1, 64'h1, 10, 32'h5, 0, 1'b0);

      if (!summary_done) begin
         summary_done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule